// File: doc/BRIEF.md
# USB Host Interrupt Aggregator

This block gathers the interrupt causes of a multi-function USB host controller and turns them into level-sensitive interrupt lines for the system. Each function has a set of cause flags. Three of the flags come from executing scheduled transactions: a completed descriptor marked for interrupt-on-completion, a short packet, and a transaction error. The fourth flag comes from a controller operation error. Each function also has a software-writable enable mask, and every cause flag can be masked by it.

Transaction causes that arrive during a frame are first collected in a hidden shadow register. They move into the visible status only when the frame's final status writeback has completed. This ensures that software, once interrupted, can safely process the frame list up to the current index minus one. Operation errors bypass this deferral. Status bits are cleared by writing ones to them.

Each function routes to a fixed system line: functions 0 and 3 share line A, function 1 uses line D, and function 2 uses line C. Each function also reports a distinct read-only pin value.

Top module: `usb_irq_aggregator`

## Requirements
- R1: After reset, every status, shadow and enable bit is 0 and all four interrupt lines are low.
- R2: A descriptor completion with its interrupt-on-completion flag set sets status bit 0 at writeback. A completion without the flag sets no bit.
- R3: Transaction causes (bit 0 completion, bit 1 short packet, bit 2 transaction error) are invisible in status, and cannot raise a line, until the function's writeback-done strobe. They appear in the cycle after the strobe.
- R4: An operation error sets status bit 3 in the cycle after the event, with no wait for writeback.
- R5: A function requests an interrupt only while some status bit is set whose enable bit is also set. Enabling an already pending bit raises the line.
- R6: A status write sets no bits: each 1 in the written data clears that status bit of the selected function, and each 0 leaves its bit unchanged.
- R7: When a cause sets a status bit in the same cycle that software clears it, the bit ends set.
- R8: A line stays high until every enabled pending cause of every function routed to it is cleared.
- R9: Line bit 0 (A) serves functions 0 and 3, bit 3 (D) serves function 1, bit 2 (C) serves function 2, and bit 1 (B) is never driven.
- R10: Function f reports pin value f+1 in its 8-bit field, so that every function's value is distinct.
- R11: A transaction cause that arrives in the same cycle as the writeback-done strobe is included in that frame's transfer. A status write does not disturb causes that are still held in the shadow register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_done | input | NUM_FUNC | Descriptor completed, one bit per function |
| ev_ioc | input | NUM_FUNC | Completed descriptor requests interrupt-on-completion |
| ev_short | input | NUM_FUNC | Short packet detected |
| ev_xerr | input | NUM_FUNC | Transaction error (CRC or timeout) |
| ev_hosterr | input | NUM_FUNC | Controller operation error |
| wb_done | input | NUM_FUNC | Final status writeback of the frame finished |
| sw_sel | input | SEL_W | Function addressed by software writes |
| sw_clr_we | input | 1 | Write-one-to-clear strobe for status |
| sw_en_we | input | 1 | Write strobe for the enable mask |
| sw_wdata | input | 4 | Software write data |
| status_o | output | NUM_FUNC*4 | Status flags, 4 bits per function |
| enable_o | output | NUM_FUNC*4 | Enable masks, 4 bits per function |
| irq_line_o | output | 4 | Interrupt lines, bit 0 = A through bit 3 = D |
| pin_val_o | output | NUM_FUNC*8 | Read-only pin value per function |

## Verification
The bench targets the deferral boundary. It checks status and lines in the cycle before and the cycle after the writeback strobe. A design that leaked transaction causes early would raise the line mid-frame. The bench also collides a set with a clear on the same bit, where a design that gave clear priority would silently drop an error. It also clears causes one at a time under a shared line, where a premature deassertion would lose a pending interrupt. Events that coincide with the strobe, and clears issued while causes are still shadowed, catch designs that drop or wipe in-flight causes.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int CAUSE_W   = 4;
    localparam int NUM_LINES = 4;
    localparam int PIN_W     = 8;

    localparam int B_IOC  = 0;
    localparam int B_SHORT = 1;
    localparam int B_XERR = 2;
    localparam int B_HERR = 3;

    typedef logic [CAUSE_W-1:0] cause_t;

    // fixed, non-uniform function-to-line routing
    function automatic int route_line(input int f);
        case (f % 4)
            0:       return 0;
            1:       return 3;
            2:       return 2;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/usb_irq_func_ctrl.sv
module usb_irq_func_ctrl
    import usb_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ev_done,
    input  logic   ev_ioc,
    input  logic   ev_short,
    input  logic   ev_xerr,
    input  logic   ev_hosterr,
    input  logic   wb_done,
    input  logic   clr_we,
    input  logic   en_we,
    input  cause_t wdata,
    output cause_t status,
    output cause_t enable,
    output logic   irq_req
);
    typedef struct packed {
        cause_t shadow;
        cause_t status;
        cause_t enable;
    } state_t;

    state_t st_d, st_q;

    cause_t new_txn;
    cause_t folded;
    cause_t set_v;
    cause_t clr_v;

    always_comb begin
        new_txn          = '0;
        new_txn[B_IOC]   = ev_done & ev_ioc;
        new_txn[B_SHORT] = ev_short;
        new_txn[B_XERR]  = ev_xerr;

        // causes of this cycle join the frame being closed
        folded = st_q.shadow | new_txn;

        set_v         = wb_done ? folded : '0;
        set_v[B_HERR] = ev_hosterr;
        clr_v         = clr_we ? wdata : '0;

        st_d        = st_q;
        st_d.shadow = wb_done ? '0 : folded;
        st_d.status = (st_q.status & ~clr_v) | set_v;   // set wins
        if (en_we) begin
            st_d.enable = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status  = st_q.status;
    assign enable  = st_q.enable;
    assign irq_req = |(st_q.status & st_q.enable);
endmodule

// File: rtl/usb_irq_router.sv
module usb_irq_router
    import usb_irq_pkg::*;
#(
    parameter int NUM_FUNC = 4
) (
    input  logic [NUM_FUNC-1:0]       req,
    output logic [NUM_LINES-1:0]      lines,
    output logic [NUM_FUNC*PIN_W-1:0] pins
);
    always_comb begin
        lines = '0;
        for (int f = 0; f < NUM_FUNC; f++) begin
            lines[route_line(f)] = lines[route_line(f)] | req[f];
        end
    end

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_pin
        assign pins[f*PIN_W +: PIN_W] = PIN_W'(f + 1);
    end
endmodule

// File: rtl/usb_irq_aggregator.sv
module usb_irq_aggregator
    import usb_irq_pkg::*;
#(
    parameter int NUM_FUNC = 4,
    localparam int SEL_W   = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_FUNC-1:0]           ev_done,
    input  logic [NUM_FUNC-1:0]           ev_ioc,
    input  logic [NUM_FUNC-1:0]           ev_short,
    input  logic [NUM_FUNC-1:0]           ev_xerr,
    input  logic [NUM_FUNC-1:0]           ev_hosterr,
    input  logic [NUM_FUNC-1:0]           wb_done,
    input  logic [SEL_W-1:0]              sw_sel,
    input  logic                          sw_clr_we,
    input  logic                          sw_en_we,
    input  logic [CAUSE_W-1:0]            sw_wdata,
    output logic [NUM_FUNC*CAUSE_W-1:0]   status_o,
    output logic [NUM_FUNC*CAUSE_W-1:0]   enable_o,
    output logic [NUM_LINES-1:0]          irq_line_o,
    output logic [NUM_FUNC*PIN_W-1:0]     pin_val_o
);
    logic [NUM_FUNC-1:0] req;

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
        logic hit;
        cause_t st, en;
        assign hit = (sw_sel == SEL_W'(f));

        usb_irq_func_ctrl u_ctrl (
            .clk        (clk),
            .rst_n      (rst_n),
            .ev_done    (ev_done[f]),
            .ev_ioc     (ev_ioc[f]),
            .ev_short   (ev_short[f]),
            .ev_xerr    (ev_xerr[f]),
            .ev_hosterr (ev_hosterr[f]),
            .wb_done    (wb_done[f]),
            .clr_we     (sw_clr_we & hit),
            .en_we      (sw_en_we & hit),
            .wdata      (sw_wdata),
            .status     (st),
            .enable     (en),
            .irq_req    (req[f])
        );

        assign status_o[f*CAUSE_W +: CAUSE_W] = st;
        assign enable_o[f*CAUSE_W +: CAUSE_W] = en;
    end

    usb_irq_router #(.NUM_FUNC(NUM_FUNC)) u_router (
        .req   (req),
        .lines (irq_line_o),
        .pins  (pin_val_o)
    );
endmodule

// File: rtl/usb_irq_checker.sv
module usb_irq_checker
    import usb_irq_pkg::*;
#(
    parameter int NUM_FUNC = 4,
    parameter int SEL_W    = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_FUNC-1:0]         wb_done,
    input logic [NUM_FUNC-1:0]         ev_hosterr,
    input logic [SEL_W-1:0]            sw_sel,
    input logic                        sw_clr_we,
    input logic                        sw_en_we,
    input logic [CAUSE_W-1:0]          sw_wdata,
    input logic [NUM_FUNC*CAUSE_W-1:0] status_o,
    input logic [NUM_LINES-1:0]        irq_line_o
);
    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_chk
        p_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ((status_o[f*CAUSE_W +: 3] & ~$past(status_o[f*CAUSE_W +: 3])) != 3'b000)
            |-> $past(wb_done[f]));

        p_hosterr_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ev_hosterr[f] |=> status_o[f*CAUSE_W + B_HERR]);

        p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_clr_we && sw_sel == SEL_W'(f) && sw_wdata[B_HERR] && !ev_hosterr[f])
            |=> !status_o[f*CAUSE_W + B_HERR]);
    end

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_line_o[k]) |-> $past(sw_clr_we || sw_en_we));
    end

    p_line_b_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_line_o[1]);
endmodule

bind usb_irq_aggregator usb_irq_checker #(.NUM_FUNC(NUM_FUNC), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wb_done    (wb_done),
    .ev_hosterr (ev_hosterr),
    .sw_sel     (sw_sel),
    .sw_clr_we  (sw_clr_we),
    .sw_en_we   (sw_en_we),
    .sw_wdata   (sw_wdata),
    .status_o   (status_o),
    .irq_line_o (irq_line_o)
);

// File: tb/usb_irq_aggregator_bench.sv
module usb_irq_aggregator_bench;
    localparam int NF = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] ev_done = '0, ev_ioc = '0, ev_short = '0, ev_xerr = '0;
    logic [NF-1:0] ev_hosterr = '0, wb_done = '0;
    logic [1:0]    sw_sel = '0;
    logic          sw_clr_we = 1'b0, sw_en_we = 1'b0;
    logic [3:0]    sw_wdata = '0;
    logic [NF*4-1:0] status_o, enable_o;
    logic [3:0]      irq_line_o;
    logic [NF*8-1:0] pin_val_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    usb_irq_aggregator u_usb_irq_aggregator (
        .clk(clk), .rst_n(rst_n),
        .ev_done(ev_done), .ev_ioc(ev_ioc), .ev_short(ev_short),
        .ev_xerr(ev_xerr), .ev_hosterr(ev_hosterr), .wb_done(wb_done),
        .sw_sel(sw_sel), .sw_clr_we(sw_clr_we), .sw_en_we(sw_en_we),
        .sw_wdata(sw_wdata), .status_o(status_o), .enable_o(enable_o),
        .irq_line_o(irq_line_o), .pin_val_o(pin_val_o)
    );

    // reference model built from the requirements
    logic [3:0] m_st [NF];
    logic [3:0] m_en [NF];
    logic [3:0] m_sh [NF];

    function automatic int line_of(int f);   // R9 routing table
        case (f)
            0: return 0;
            1: return 3;
            2: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [3:0] exp_lines();
        logic [3:0] l = '0;
        for (int f = 0; f < NF; f++)
            if ((m_st[f] & m_en[f]) != 0) l[line_of(f)] = 1'b1;
        return l;
    endfunction

    typedef struct {
        string      req;
        int         f;
        logic [3:0] st;
        logic [3:0] en;
        logic [3:0] ln;
    } exp_t;

    exp_t sb[$];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expectations and compares at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            check({it.req, " status"}, 32'(status_o[it.f*4 +: 4]), 32'(it.st));
            check({it.req, " enable"}, 32'(enable_o[it.f*4 +: 4]), 32'(it.en));
            check({it.req, " lines"},  32'(irq_line_o), 32'(it.ln));
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic expect_f(string req, int f);
        exp_t it;
        it.req = req; it.f = f; it.st = m_st[f]; it.en = m_en[f]; it.ln = exp_lines();
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    // driver: one cycle of stimulus, model updated alongside
    // ev = {hosterr, xerr, short, ioc, done}
    task automatic step(int f, logic [4:0] ev, bit wb, bit clr, bit en, logic [3:0] wd);
        logic [3:0] nt, fold, setv;
        ev_done[f] = ev[0]; ev_ioc[f] = ev[1]; ev_short[f] = ev[2];
        ev_xerr[f] = ev[3]; ev_hosterr[f] = ev[4]; wb_done[f] = wb;
        sw_sel = 2'(f); sw_clr_we = clr; sw_en_we = en; sw_wdata = wd;
        nt   = {1'b0, ev[3], ev[2], ev[0] & ev[1]};
        fold = m_sh[f] | nt;
        setv = (wb ? fold : 4'b0) | {ev[4], 3'b000};
        m_st[f] = (m_st[f] & ~(clr ? wd : 4'b0)) | setv;
        m_sh[f] = wb ? 4'b0 : fold;
        if (en) m_en[f] = wd;
        tick();
        ev_done = '0; ev_ioc = '0; ev_short = '0; ev_xerr = '0;
        ev_hosterr = '0; wb_done = '0; sw_clr_we = 0; sw_en_we = 0;
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int f = 0; f < NF; f++) begin m_st[f] = 0; m_en[f] = 0; m_sh[f] = 0; end
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state, R10 pin values
        for (int f = 0; f < NF; f++) expect_f("R1 reset", f);
        for (int f = 0; f < NF; f++) check("R10 pin", 32'(pin_val_o[f*8 +: 8]), 32'(f + 1));

        // enable everything except function 3
        for (int f = 0; f < 3; f++) begin step(f, 5'b0, 0, 0, 1, 4'hF); expect_f("R5 enable write", f); end

        // R2/R3: completion with flag deferred until writeback
        step(0, 5'b00011, 0, 0, 0, 0);
        expect_f("R3 deferred before writeback", 0);
        step(0, 5'b0, 1, 0, 0, 0);
        expect_f("R2 completion visible after writeback", 0);
        step(0, 5'b0, 0, 1, 0, 4'b0001);
        expect_f("R6 clear bit0", 0);
        step(0, 5'b00001, 1, 0, 0, 0);   // no flag
        expect_f("R2 completion without flag", 0);

        // R3 + R9 + R8 on function 1 (line D)
        step(1, 5'b01100, 0, 0, 0, 0);
        expect_f("R3 short/err hidden", 1);
        step(1, 5'b0, 1, 0, 0, 0);
        expect_f("R9 line D", 1);
        step(1, 5'b0, 0, 1, 0, 4'b0010);
        expect_f("R8 partial clear keeps line", 1);
        step(1, 5'b0, 0, 1, 0, 4'b0100);
        expect_f("R8 final clear drops line", 1);

        // R4 operation error, function 2 (line C)
        step(2, 5'b10000, 0, 0, 0, 0);
        expect_f("R4 hosterr immediate line C", 2);
        // R7 set vs clear same cycle
        step(2, 5'b10000, 0, 1, 0, 4'b1000);
        expect_f("R7 set wins", 2);
        step(2, 5'b0, 0, 1, 0, 4'b1000);
        expect_f("R6 clear hosterr", 2);

        // R5 masked function 3, then enable
        step(3, 5'b10000, 0, 0, 0, 0);
        expect_f("R5 masked no line", 3);
        step(3, 5'b0, 0, 0, 1, 4'b1000);
        expect_f("R5 enable raises line A", 3);
        // R8 shared line: function 0 pending too
        step(0, 5'b10000, 0, 0, 0, 0);
        step(3, 5'b0, 0, 1, 0, 4'b1000);
        expect_f("R8 shared line A held by func0", 3);
        step(0, 5'b0, 0, 1, 0, 4'b1000);
        expect_f("R8 line A released", 0);

        // R11 same-cycle event and strobe; clear during frame keeps shadow
        step(1, 5'b01000, 1, 0, 0, 0);
        expect_f("R11 same-cycle capture", 1);
        step(1, 5'b0, 0, 1, 0, 4'b0100);
        step(0, 5'b00100, 0, 0, 0, 0);
        step(0, 5'b0, 0, 1, 0, 4'b0010);
        expect_f("R11 clear while shadowed", 0);
        step(0, 5'b0, 1, 0, 0, 0);
        expect_f("R11 shadow survives clear", 0);

        repeat (3) tick();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule